// File: doc/BRIEF.md
# Serial memory target protocol engine

This block is the bus-facing half of a 128-byte two-wire serial memory. It runs on a fast system clock, oversamples the SCL and SDA lines through synchronizers, and recognises Start and Stop conditions and the data bits clocked in between them. It decodes the control byte that follows each Start, compares its select field with three strap inputs, acknowledges by pulling SDA low, and then either loads a word address or streams memory bytes back to the host.

A single 7-bit address pointer serves every access. A write transfer loads it from the byte after the control byte. A read transfer starts at the pointer, and the pointer advances past each byte that is sent. This gives current-address reads, random reads (address write, repeated Start, read) and sequential reads that wrap from the top of the array to zero. While the external write engine reports busy, the block acknowledges nothing, so the host can poll for completion by retrying a control byte.

Top module: `i2c_eeprom_target`

## Requirements
- R1: After reset, and with no traffic, `sda_pull_o` is 0 (SDA released).
- R2: The control byte is 8 bits MSB first: bits 7..4 the device code 1010, bits 3..1 the select field, bit 0 direction (1 read, 0 write). When the code is 1010 and the select field equals `strap_i[2:0]`, the block pulls SDA low during the ninth clock.
- R3: A control byte with a different code or a select field unequal to the straps gets no acknowledge, and the block stays off the bus until the next Start.
- R4: While `busy_i` is 1 at the end of a received byte, that byte (control, address or data) is not acknowledged and the pointer is not loaded.
- R5: In a write transfer the byte after the control byte is acknowledged and its low 7 bits (bit 7 ignored) are loaded into the pointer; a repeated Start plus a read control byte then reads from that address.
- R6: A read returns the byte at the pointer, which holds the last read address plus one.
- R7: In a read, a host ACK (SDA low on the ninth clock) makes the block send the next byte; a host NACK leaves SDA released until the next Start.
- R8: The pointer wraps from address 127 to address 0 when a byte is read from 127.
- R9: `sda_pull_o` only goes from 0 to 1 while the synchronized SCL is low.
- R10: A Start seen at any bit position aborts the byte in progress, releases SDA and begins a new control byte.
- R11: A Stop seen at any bit position aborts the byte in progress, releases SDA and leaves the pointer unchanged.
- R12: Data bytes after the address byte in a write transfer are acknowledged and do not move the pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, at least 8x the SCL rate |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| strap_i | input | 3 | Select strap levels compared with control bits 3..1 |
| busy_i | input | 1 | Write engine busy; suppresses every acknowledge |
| mem_addr_o | output | 7 | Read address into the memory (the pointer) |
| mem_rdata_i | input | 8 | Byte at `mem_addr_o`, valid in the same cycle |
| sda_pull_o | output | 1 | 1 pulls SDA low (open-drain enable) |

## Verification
The bench hunts for pointer slips: a random read whose address byte has bit 7 set, a sequential read across 127 to 0, and write data bytes that must not move the pointer; a design that incremented on writes or wrapped wrongly returns the wrong byte on the following current-address read. It raises busy both before a control byte and in the middle of a write, where a design that ignored busy would acknowledge and load a new address. It cuts a control byte with a Start and an address byte with a Stop; a design that kept its bit count would misframe the next byte or load a stale address. It also watches that SDA is released in the host acknowledge slot after a NACK, which a design that kept transmitting would violate.

// File: rtl/i2ct_pkg.sv
package i2ct_pkg;
  typedef enum logic [2:0] {ST_IDLE, ST_RX, ST_ACK, ST_TX, ST_HACK} st_e;
  typedef enum logic [1:0] {K_CTRL, K_ADDR, K_DATA} kind_e;
endpackage

// File: rtl/i2ct_sync.sv
module i2ct_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_ff, sda_ff;
  logic scl_d, sda_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[STAGES-2:0], scl_i};
      sda_ff <= {sda_ff[STAGES-2:0], sda_i};
      scl_d  <= scl_ff[STAGES-1];
      sda_d  <= sda_ff[STAGES-1];
    end
  end

  assign scl_o      = scl_ff[STAGES-1];
  assign sda_o      = sda_ff[STAGES-1];
  assign scl_rise_o = scl_o & ~scl_d;
  assign scl_fall_o = ~scl_o & scl_d;
  // SDA edge while SCL held high
  assign start_o    = scl_o & scl_d & ~sda_o & sda_d;
  assign stop_o     = scl_o & scl_d & sda_o & ~sda_d;
endmodule

// File: rtl/i2ct_ptr.sv
module i2ct_ptr #(
  parameter int AW = 7
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [AW-1:0] load_val_i,
  input  logic          inc_i,
  output logic [AW-1:0] ptr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ptr_o <= '0;
    else if (load_i) ptr_o <= load_val_i;
    else if (inc_i)  ptr_o <= ptr_o + 1'b1;
  end

  assert_ptr_wrap_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !load_i && ptr_o == {AW{1'b1}}) |=> ptr_o == '0);
  assert_ptr_load_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> ptr_o == $past(load_val_i));
endmodule

// File: rtl/i2ct_fsm.sv
module i2ct_fsm
  import i2ct_pkg::*;
#(
  parameter int         DW       = 8,
  parameter int         AW       = 7,
  parameter int         SEL_W    = 3,
  parameter logic [3:0] DEV_CODE = 4'b1010
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             scl_i,
  input  logic             sda_i,
  input  logic             scl_rise_i,
  input  logic             scl_fall_i,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic [SEL_W-1:0] strap_i,
  input  logic             busy_i,
  input  logic [DW-1:0]    rdata_i,
  output logic             ptr_load_o,
  output logic [AW-1:0]    ptr_val_o,
  output logic             ptr_inc_o,
  output logic             pull_o
);
  localparam int CNT_W = $clog2(DW + 1);
  localparam int CW    = DW - SEL_W - 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DW);

  st_e              st_q;
  kind_e            kind_q;
  logic [CNT_W-1:0] cnt_q;
  logic [DW-1:0]    sh_q, tx_q;
  logic             rd_q, hack_q, ack_ok, byte_end;

  assign byte_end   = (st_q == ST_RX) && scl_fall_i && (cnt_q == LAST);
  assign ack_ok     = !busy_i && ((kind_q != K_CTRL) ||
                      ((sh_q[DW-1 -: CW] == DEV_CODE[CW-1:0]) && (sh_q[SEL_W:1] == strap_i)));
  assign ptr_load_o = byte_end && ack_ok && (kind_q == K_ADDR);
  assign ptr_val_o  = sh_q[AW-1:0];
  assign ptr_inc_o  = (st_q == ST_TX) && scl_fall_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      kind_q <= K_CTRL;
      cnt_q  <= '0;
      sh_q   <= '0;
      tx_q   <= '0;
      rd_q   <= 1'b0;
      hack_q <= 1'b0;
      pull_o <= 1'b0;
    end else if (start_i) begin
      st_q   <= ST_RX;
      kind_q <= K_CTRL;
      cnt_q  <= '0;
      pull_o <= 1'b0;
    end else if (stop_i) begin
      st_q   <= ST_IDLE;
      pull_o <= 1'b0;
    end else begin
      unique case (st_q)
        ST_RX: begin
          if (scl_rise_i && cnt_q != LAST) begin
            sh_q  <= {sh_q[DW-2:0], sda_i};
            cnt_q <= cnt_q + 1'b1;
          end else if (byte_end) begin
            if (ack_ok) begin
              pull_o <= 1'b1;
              st_q   <= ST_ACK;
              rd_q   <= (kind_q == K_CTRL) && sh_q[0];
              kind_q <= (kind_q == K_CTRL) ? K_ADDR : K_DATA;
            end else begin
              st_q <= ST_IDLE;
            end
          end
        end
        ST_ACK: begin
          if (scl_fall_i) begin
            if (rd_q) begin
              pull_o <= ~rdata_i[DW-1];
              tx_q   <= {rdata_i[DW-2:0], 1'b0};
              cnt_q  <= CNT_W'(1);
              st_q   <= ST_TX;
            end else begin
              pull_o <= 1'b0;
              cnt_q  <= '0;
              st_q   <= ST_RX;
            end
          end
        end
        ST_TX: begin
          if (scl_fall_i) begin
            if (cnt_q == LAST) begin
              pull_o <= 1'b0;
              st_q   <= ST_HACK;
            end else begin
              pull_o <= ~tx_q[DW-1];
              tx_q   <= {tx_q[DW-2:0], 1'b0};
              cnt_q  <= cnt_q + 1'b1;
            end
          end
        end
        ST_HACK: begin
          if (scl_rise_i) hack_q <= ~sda_i;
          else if (scl_fall_i) begin
            if (hack_q) begin
              pull_o <= ~rdata_i[DW-1];
              tx_q   <= {rdata_i[DW-2:0], 1'b0};
              cnt_q  <= CNT_W'(1);
              st_q   <= ST_TX;
            end else begin
              st_q <= ST_IDLE;
            end
          end
        end
        default: pull_o <= 1'b0;
      endcase
    end
  end

  assert_release_stop_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> !pull_o && st_q == ST_IDLE);
  assert_restart_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> !pull_o && st_q == ST_RX && cnt_q == '0);
  assert_pull_scl_low_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pull_o) |-> !scl_i);
  assert_host_slot_free_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_q == ST_HACK |-> !pull_o);
  assert_busy_no_ack_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_end && busy_i && !start_i && !stop_i) |=> !pull_o && st_q == ST_IDLE);
endmodule

// File: rtl/i2c_eeprom_target.sv
module i2c_eeprom_target #(
  parameter int         DW       = 8,
  parameter int         AW       = 7,
  parameter int         SEL_W    = 3,
  parameter int         STAGES   = 2,
  parameter logic [3:0] DEV_CODE = 4'b1010
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             scl_i,
  input  logic             sda_i,
  input  logic [SEL_W-1:0] strap_i,
  input  logic             busy_i,
  output logic [AW-1:0]    mem_addr_o,
  input  logic [DW-1:0]    mem_rdata_i,
  output logic             sda_pull_o
);
  logic scl_s, sda_s, scl_rise, scl_fall, start, stop;
  logic ptr_load, ptr_inc;
  logic [AW-1:0] ptr_val;

  i2ct_sync #(.STAGES(STAGES)) u_sync (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .scl_o(scl_s), .sda_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start), .stop_o(stop)
  );

  i2ct_fsm #(.DW(DW), .AW(AW), .SEL_W(SEL_W), .DEV_CODE(DEV_CODE)) u_fsm (
    .clk_i, .rst_ni, .scl_i(scl_s), .sda_i(sda_s), .scl_rise_i(scl_rise),
    .scl_fall_i(scl_fall), .start_i(start), .stop_i(stop), .strap_i, .busy_i,
    .rdata_i(mem_rdata_i), .ptr_load_o(ptr_load), .ptr_val_o(ptr_val),
    .ptr_inc_o(ptr_inc), .pull_o(sda_pull_o)
  );

  i2ct_ptr #(.AW(AW)) u_ptr (
    .clk_i, .rst_ni, .load_i(ptr_load), .load_val_i(ptr_val),
    .inc_i(ptr_inc), .ptr_o(mem_addr_o)
  );
endmodule

// File: tb/tb_i2c_eeprom_target.sv
module tb_i2c_eeprom_target;
  logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, sda_h = 1'b1, busy = 1'b0;
  logic [2:0] strap = 3'b101;
  logic [6:0] mem_addr;
  logic [7:0] mem_rdata;
  logic pull, pull_prev = 1'b0;
  wire  sda_bus = sda_h & ~pull;
  int total = 0, bad = 0, exp_ptr = 0, rise_viol = 0;
  bit done = 1'b0;

  localparam logic [7:0] CW = 8'hAA;  // 1010 101 0
  localparam logic [7:0] CR = 8'hAB;  // 1010 101 1

  always #10 clk = ~clk;

  function automatic logic [7:0] mem_fn(int a);
    return 8'((a * 37 + 11) & 8'hFF);
  endfunction
  assign mem_rdata = mem_fn(int'(mem_addr));

  i2c_eeprom_target dut (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .sda_i(sda_bus), .strap_i(strap),
    .busy_i(busy), .mem_addr_o(mem_addr), .mem_rdata_i(mem_rdata), .sda_pull_o(pull)
  );

  // per-clock watch: R9 pull may only rise while SCL is low
  always @(negedge clk) begin
    if (rst_n && pull && !pull_prev && scl) rise_viol++;
    pull_prev <= pull;
  end

  task automatic chk(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic w(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    w(4); sda_h = 1'b1; w(12); scl = 1'b1; w(8); sda_h = 1'b0; w(8); scl = 1'b0;
  endtask

  task automatic bus_stop();
    w(4); sda_h = 1'b0; w(12); scl = 1'b1; w(8); sda_h = 1'b1; w(16);
  endtask

  task automatic bit_cyc(input bit b, output bit seen);
    w(4); sda_h = b; w(12); scl = 1'b1; w(8); seen = sda_bus; w(8); scl = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    bit s;
    for (int i = 7; i >= 0; i--) bit_cyc(b[i], s);
    bit_cyc(1'b1, s);
    ack = !s;
  endtask

  task automatic recv_byte(input bit hack, output logic [7:0] d, output bit slot);
    bit s;
    for (int i = 7; i >= 0; i--) begin
      bit_cyc(1'b1, s);
      d[i] = s;
    end
    bit_cyc(!hack, slot);
  endtask

  task automatic set_ptr(input logic [7:0] a, string req);
    bit ack;
    bus_start();
    send_byte(CW, ack);
    chk(ack, {req, " control ack"}, ack, 1);
    send_byte(a, ack);
    chk(ack, {req, " address ack"}, ack, 1);
    exp_ptr = int'(a[6:0]);
  endtask

  task automatic read_n(int n, string req);
    logic [7:0] d;
    bit slot;
    for (int k = 0; k < n; k++) begin
      recv_byte(k != n - 1, d, slot);
      chk(d == mem_fn(exp_ptr), {req, " read data"}, d, mem_fn(exp_ptr));
      exp_ptr = (exp_ptr + 1) % 128;
    end
    chk(slot == 1'b1, "R7 SDA free in host NACK slot", slot, 1);
  endtask

  task automatic cur_read(int n, string req);
    bit ack;
    bus_start();
    send_byte(CR, ack);
    chk(ack, {req, " read control ack"}, ack, 1);
    read_n(n, req);
    w(6);
    chk(pull == 1'b0, "R7 released after NACK", pull, 0);
    bus_stop();
  endtask

  initial begin
    bit ack, s;
    w(5);
    chk(pull == 1'b0, "R1 reset released", pull, 0);
    rst_n = 1'b1;
    w(10);
    chk(pull == 1'b0, "R1 idle released", pull, 0);

    // R2 R5 R12: write transfer with two data bytes
    set_ptr(8'h10, "R2/R5");
    send_byte(8'h55, ack);
    chk(ack, "R12 data byte ack", ack, 1);
    send_byte(8'h66, ack);
    chk(ack, "R12 second data ack", ack, 1);
    bus_stop();
    cur_read(1, "R12 pointer unmoved by data");
    cur_read(1, "R6 current address");

    // R3 mismatches
    bus_start(); send_byte(8'hBA, ack);
    chk(!ack, "R3 wrong code", ack, 0);
    bus_stop();
    bus_start(); send_byte(8'hA8, ack);
    chk(!ack, "R3 wrong select", ack, 0);
    bus_stop();

    // R5 R7 random + sequential read; address bit 7 ignored
    set_ptr(8'hC0, "R5");
    bus_start();
    send_byte(CR, ack);
    chk(ack, "R5 repeated start read ack", ack, 1);
    read_n(3, "R7 sequential");
    bus_stop();
    cur_read(1, "R6 after sequential");

    // R8 wrap
    set_ptr(8'hFE, "R8");
    bus_start();
    send_byte(CR, ack);
    chk(ack, "R8 read ack", ack, 1);
    read_n(3, "R8 wrap");
    bus_stop();
    chk(exp_ptr == 1, "R8 model pointer", exp_ptr, 1);
    cur_read(1, "R8 after wrap");

    // R4 busy polling
    busy = 1'b1;
    bus_start(); send_byte(CW, ack);
    chk(!ack, "R4 busy write control", ack, 0);
    bus_stop();
    bus_start(); send_byte(CR, ack);
    chk(!ack, "R4 busy read control", ack, 0);
    bus_stop();
    busy = 1'b0;
    bus_start(); send_byte(CW, ack);
    chk(ack, "R4 ack after busy clears", ack, 1);
    busy = 1'b1;
    send_byte(8'h33, ack);
    chk(!ack, "R4 busy address byte", ack, 0);
    bus_stop();
    busy = 1'b0;
    cur_read(1, "R4 pointer not loaded when busy");

    // R10 start mid control byte
    bus_start();
    bit_cyc(1'b1, s); bit_cyc(1'b0, s); bit_cyc(1'b1, s); bit_cyc(1'b1, s);
    bus_start();
    send_byte(CR, ack);
    chk(ack, "R10 restart control ack", ack, 1);
    read_n(1, "R10");
    bus_stop();

    // R11 stop mid address byte
    bus_start();
    send_byte(CW, ack);
    chk(ack, "R11 control ack", ack, 1);
    bit_cyc(1'b0, s); bit_cyc(1'b1, s); bit_cyc(1'b1, s);
    bus_stop();
    chk(pull == 1'b0, "R11 released after stop", pull, 0);
    cur_read(1, "R11 pointer unchanged");

    chk(rise_viol == 0, "R9 pull rose with SCL high", rise_viol, 0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog R1 act=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule